// File: doc/BRIEF.md
# I2C Register Target

This block is a slave-only I2C target that lets a bus host read and write a bank of 8-bit control registers. It samples the SCL and SDA lines with the system clock, finds START, repeated START and STOP conditions, and answers a 7-bit device address. The upper six address bits are fixed and the lowest bit comes from a strap input. The block never drives SCL and never creates bus conditions. It only pulls SDA low, through an open-drain enable output, to acknowledge or to send zero bits.

A host writes by sending the device address with R/W=0, then a subaddress byte that loads the register pointer, then any number of data bytes. To read, the host first sets the pointer the same way, then issues a repeated START, the device address with R/W=1, and clocks data out. It acknowledges every byte but the last, which it NAKs. The pointer advances by one after every data byte in either direction and wraps from FFh to 00h.

Top module: `i2c_reg_target`

## Requirements
- R1: The device address is {101110, strap, R/W} (write/read bytes B8h/B9h with strap 0, BAh/BBh with strap 1). The target pulls SDA low during the ninth clock only when the seven address bits match.
- R2: The strap level is captured while reset is low and the value present when reset is released is kept. Strap changes after reset do not alter the address.
- R3: In a write, the first byte after the address loads the pointer. Each following byte is ACKed and stored in the register the pointer selects.
- R4: After a repeated START and a read address, the target sends the selected register MSB first. The pointer keeps its value across the repeated START, and any START puts the target back into address reception.
- R5: The pointer increments after every data byte, read or write, and wraps from FFh to 00h.
- R6: After the host NAKs a read byte, the target releases SDA and drives nothing until the next START; further clocking reads all ones.
- R7: On an address mismatch the target does not ACK, ignores the bytes that follow and leaves every register unchanged until a START or STOP.
- R8: After reset SDA is released, the pointer is 00h and every register reads 00h.
- R9: The SDA pull-down changes only while the synchronized SCL is low, so it is stable during every SCL high phase.
- R10: After a STOP the target is idle: bytes clocked without a new START are not acknowledged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, several times faster than SCL |
| rst_n | input | 1 | Active-low reset; the strap is captured while it is low |
| addr_strap | input | 1 | Strap level giving the address LSB |
| scl_i | input | 1 | Sensed level of the SCL line |
| sda_i | input | 1 | Sensed level of the SDA line |
| sda_pull_o | output | 1 | 1 pulls SDA low (open-drain enable), 0 releases it |

## Verification
A wrong FSM state or bit count shows up at the ports within one byte. The ACK window then moves or disappears, or read bits come out shifted by a position. A pointer error stays hidden until the next data byte, when the value read back or the location written is wrong. For that reason each write is followed by a read of the same and the neighbouring registers. A strap latched at the wrong moment shows only on the next address byte, as an ACK for the wrong device.

// File: rtl/i2ct_pkg.sv
package i2ct_pkg;
  localparam int BYTE_W = 8;
  localparam logic [5:0] DEV_HI = 6'b101110;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_DEV,
    ST_DEV_ACK,
    ST_SUB,
    ST_SUB_ACK,
    ST_WR,
    ST_WR_ACK,
    ST_RD,
    ST_RD_ACK,
    ST_IGNORE
  } tgt_state_e;

  function automatic logic [6:0] dev_id(input logic strap);
    return {DEV_HI, strap};
  endfunction

  function automatic logic addr_hit(input logic [BYTE_W-1:0] b, input logic strap);
    return b[BYTE_W-1:1] == dev_id(strap);
  endfunction
endpackage

// File: rtl/i2ct_sync.sv
module i2ct_sync #(
  parameter int LINES  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] pin_i,
  output logic [LINES-1:0] lvl_o,
  output logic [LINES-1:0] rise_o,
  output logic [LINES-1:0] fall_o
);
  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic [STAGES:0] chain_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '1;
      else        chain_q <= {chain_q[STAGES-1:0], pin_i[g]};
    end
    assign lvl_o[g]  = chain_q[STAGES-1];
    assign rise_o[g] = chain_q[STAGES-1] & ~chain_q[STAGES];
    assign fall_o[g] = ~chain_q[STAGES-1] & chain_q[STAGES];
  end
endmodule

// File: rtl/i2ct_regbank.sv
module i2ct_regbank #(
  parameter int PTR_W  = 8,
  parameter int REGS   = 256,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [PTR_W-1:0]  waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [PTR_W-1:0]  raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int IDX_W = (REGS > 1) ? $clog2(REGS) : 1;

  logic [DATA_W-1:0] regs_q [REGS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < REGS; i++) regs_q[i] <= '0;
    end else if (we && (int'(waddr) < REGS)) begin
      regs_q[waddr[IDX_W-1:0]] <= wdata;
    end
  end

  always_comb begin
    if (int'(raddr) < REGS) rdata = regs_q[raddr[IDX_W-1:0]];
    else                    rdata = '0;
  end
endmodule

// File: rtl/i2ct_engine.sv
module i2ct_engine
  import i2ct_pkg::*;
#(
  parameter int PTR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strap_q,
  input  logic              scl_s,
  input  logic              sda_s,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_ev,
  input  logic              stop_ev,
  input  logic [BYTE_W-1:0] rd_data,
  output logic              wr_stb,
  output logic [BYTE_W-1:0] wr_data,
  output logic [PTR_W-1:0]  ptr_o,
  output logic              sda_oe,
  output logic              st_idle,
  output logic              st_addr,
  output logic              st_ignore,
  output logic              nak_ev
);
  localparam int CNT_W = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] LAST_RX = CNT_W'(BYTE_W - 1);
  localparam logic [CNT_W-1:0] ALL_TX  = CNT_W'(BYTE_W);

  tgt_state_e        st_q;
  logic [CNT_W-1:0]  bitcnt_q;
  logic [BYTE_W-1:0] sh_q;
  logic [PTR_W-1:0]  ptr_q;
  logic              oe_q;
  logic              rw_q;
  logic              mnak_q;
  logic              bus_evt;
  logic [BYTE_W-1:0] rx_byte;
  logic              rx_last;

  assign bus_evt = start_ev | stop_ev;
  assign rx_byte = {sh_q[BYTE_W-2:0], sda_s};
  assign rx_last = scl_rise && (bitcnt_q == LAST_RX);

  assign wr_stb    = (st_q == ST_WR) && rx_last && !bus_evt;
  assign wr_data   = rx_byte;
  assign nak_ev    = (st_q == ST_RD_ACK) && scl_fall && mnak_q && !bus_evt;
  assign ptr_o     = ptr_q;
  assign sda_oe    = oe_q;
  assign st_idle   = (st_q == ST_IDLE);
  assign st_addr   = (st_q == ST_DEV);
  assign st_ignore = (st_q == ST_IGNORE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      bitcnt_q <= '0;
      sh_q     <= '0;
      ptr_q    <= '0;
      oe_q     <= 1'b0;
      rw_q     <= 1'b0;
      mnak_q   <= 1'b0;
    end else if (stop_ev) begin
      st_q <= ST_IDLE;
      oe_q <= 1'b0;
    end else if (start_ev) begin
      st_q     <= ST_DEV;
      bitcnt_q <= '0;
      oe_q     <= 1'b0;
    end else begin
      unique case (st_q)
        ST_DEV, ST_SUB, ST_WR: begin
          if (scl_rise) begin
            sh_q <= rx_byte;
            if (bitcnt_q == LAST_RX) begin
              bitcnt_q <= '0;
              if (st_q == ST_DEV) begin
                if (addr_hit(rx_byte, strap_q)) begin
                  rw_q <= rx_byte[0];
                  st_q <= ST_DEV_ACK;
                end else begin
                  st_q <= ST_IGNORE;
                end
              end else if (st_q == ST_SUB) begin
                ptr_q <= rx_byte;
                st_q  <= ST_SUB_ACK;
              end else begin
                ptr_q <= ptr_q + 1'b1;
                st_q  <= ST_WR_ACK;
              end
            end else begin
              bitcnt_q <= bitcnt_q + 1'b1;
            end
          end
        end
        ST_DEV_ACK, ST_SUB_ACK, ST_WR_ACK: begin
          if (scl_fall) begin
            if (!oe_q) begin
              oe_q <= 1'b1;
            end else if ((st_q == ST_DEV_ACK) && rw_q) begin
              sh_q     <= rd_data;
              ptr_q    <= ptr_q + 1'b1;
              oe_q     <= ~rd_data[BYTE_W-1];
              bitcnt_q <= '0;
              st_q     <= ST_RD;
            end else begin
              oe_q     <= 1'b0;
              bitcnt_q <= '0;
              st_q     <= (st_q == ST_DEV_ACK) ? ST_SUB : ST_WR;
            end
          end
        end
        ST_RD: begin
          if (scl_rise) begin
            bitcnt_q <= bitcnt_q + 1'b1;
          end else if (scl_fall) begin
            if (bitcnt_q == ALL_TX) begin
              oe_q <= 1'b0;
              st_q <= ST_RD_ACK;
            end else begin
              sh_q <= {sh_q[BYTE_W-2:0], 1'b0};
              oe_q <= ~sh_q[BYTE_W-2];
            end
          end
        end
        ST_RD_ACK: begin
          if (scl_rise) begin
            mnak_q <= sda_s;
          end else if (scl_fall) begin
            if (mnak_q) begin
              st_q <= ST_IGNORE;
            end else begin
              sh_q     <= rd_data;
              ptr_q    <= ptr_q + 1'b1;
              oe_q     <= ~rd_data[BYTE_W-1];
              bitcnt_q <= '0;
              st_q     <= ST_RD;
            end
          end
        end
        default: begin
          oe_q <= 1'b0;
        end
      endcase
    end
  end

  logic unused_scl;
  assign unused_scl = scl_s;
endmodule

// File: rtl/i2c_reg_target.sv
module i2c_reg_target
  import i2ct_pkg::*;
#(
  parameter int PTR_W       = 8,
  parameter int REG_COUNT   = 256,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic addr_strap,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_pull_o
);
  localparam int IDX_SCL = 0;
  localparam int IDX_SDA = 1;

  logic [1:0]        pin_lvl, pin_rise, pin_fall;
  logic              scl_s, sda_s, scl_rise, scl_fall;
  logic              start_ev, stop_ev;
  logic              strap_q;
  logic              wr_stb;
  logic [BYTE_W-1:0] wr_data, rd_data;
  logic [PTR_W-1:0]  ptr;
  logic              st_idle, st_addr, st_ignore, nak_ev;

  always_ff @(posedge clk) begin
    if (!rst_n) strap_q <= addr_strap;
  end

  i2ct_sync #(.LINES(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .pin_i  ({sda_i, scl_i}),
    .lvl_o  (pin_lvl),
    .rise_o (pin_rise),
    .fall_o (pin_fall)
  );

  assign scl_s    = pin_lvl[IDX_SCL];
  assign sda_s    = pin_lvl[IDX_SDA];
  assign scl_rise = pin_rise[IDX_SCL];
  assign scl_fall = pin_fall[IDX_SCL];
  assign start_ev = pin_fall[IDX_SDA] & scl_s;
  assign stop_ev  = pin_rise[IDX_SDA] & scl_s;

  i2ct_engine #(.PTR_W(PTR_W)) u_engine (
    .clk       (clk),
    .rst_n     (rst_n),
    .strap_q   (strap_q),
    .scl_s     (scl_s),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_ev  (start_ev),
    .stop_ev   (stop_ev),
    .rd_data   (rd_data),
    .wr_stb    (wr_stb),
    .wr_data   (wr_data),
    .ptr_o     (ptr),
    .sda_oe    (sda_pull_o),
    .st_idle   (st_idle),
    .st_addr   (st_addr),
    .st_ignore (st_ignore),
    .nak_ev    (nak_ev)
  );

  i2ct_regbank #(.PTR_W(PTR_W), .REGS(REG_COUNT), .DATA_W(BYTE_W)) u_bank (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (wr_stb),
    .waddr (ptr),
    .wdata (wr_data),
    .raddr (ptr),
    .rdata (rd_data)
  );
endmodule

// File: rtl/i2ct_checker.sv
module i2ct_checker #(
  parameter int PTR_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             scl_s,
  input logic             sda_pull_o,
  input logic             strap_q,
  input logic             st_idle,
  input logic             st_addr,
  input logic             st_ignore,
  input logic             start_ev,
  input logic             nak_ev,
  input logic             wr_stb,
  input logic [PTR_W-1:0] ptr
);
  AST_PULL_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_pull_o) |-> !scl_s); // R9
  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    st_idle |-> !sda_pull_o); // R10
  AST_IGNORE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    st_ignore |-> !sda_pull_o); // R7
  AST_STRAP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> $stable(strap_q)); // R2
  AST_NAK_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    nak_ev |=> (st_ignore && !sda_pull_o)); // R6
  AST_START_REARM: assert property (@(posedge clk) disable iff (!rst_n)
    start_ev |=> (st_addr && !sda_pull_o)); // R4
  AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> (ptr == $past(ptr) + 1'b1)); // R5
  AST_PTR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && (&ptr)) |=> (ptr == '0)); // R5
endmodule

bind i2c_reg_target i2ct_checker #(.PTR_W(PTR_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .scl_s      (scl_s),
  .sda_pull_o (sda_pull_o),
  .strap_q    (strap_q),
  .st_idle    (st_idle),
  .st_addr    (st_addr),
  .st_ignore  (st_ignore),
  .start_ev   (start_ev),
  .nak_ev     (nak_ev),
  .wr_stb     (wr_stb),
  .ptr        (ptr)
);

// File: tb/i2c_reg_target_tb.sv
`timescale 1ns/1ps
module i2c_reg_target_tb;
  localparam int Q = 50;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic addr_strap = 1'b0;
  logic m_scl = 1'b1;
  logic m_sda = 1'b1;
  logic sda_pull_o;
  logic line;
  int total = 0;
  int bad = 0;

  assign line = m_sda & ~sda_pull_o;

  always #5 clk = ~clk;

  i2c_reg_target u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .addr_strap (addr_strap),
    .scl_i      (m_scl),
    .sda_i      (line),
    .sda_pull_o (sda_pull_o)
  );

  task automatic check_eq(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset(input logic strap);
    rst_n = 1'b0;
    addr_strap = strap;
    m_scl = 1'b1;
    m_sda = 1'b1;
    repeat (6) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (6) @(posedge clk);
  endtask

  task automatic bus_start;
    m_sda = 1'b1; #Q;
    m_scl = 1'b1; #Q;
    m_sda = 1'b0; #Q;
    m_scl = 1'b0; #Q;
  endtask

  task automatic bus_stop;
    m_sda = 1'b0; #Q;
    m_scl = 1'b1; #Q;
    m_sda = 1'b1; #(2*Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic acked);
    for (int i = 7; i >= 0; i--) begin
      m_sda = b[i]; #Q;
      m_scl = 1'b1; #(2*Q);
      m_scl = 1'b0; #Q;
    end
    m_sda = 1'b1; #Q;
    m_scl = 1'b1; #Q;
    acked = (line == 1'b0);
    #Q;
    m_scl = 1'b0; #Q;
  endtask

  task automatic recv_byte(input logic nak, output logic [7:0] d, output logic glitch);
    glitch = 1'b0;
    for (int i = 7; i >= 0; i--) begin
      m_sda = 1'b1; #Q;
      m_scl = 1'b1; #Q;
      d[i] = line;
      #(Q-10);
      if (line !== d[i]) glitch = 1'b1;
      #10;
      m_scl = 1'b0; #Q;
    end
    m_sda = nak; #Q;
    m_scl = 1'b1; #(2*Q);
    m_scl = 1'b0; #Q;
  endtask

  task automatic read_one(input logic [7:0] dev_w, input logic [7:0] sub, input string tag,
                          input logic [7:0] exp);
    logic a;
    logic g;
    logic [7:0] d;
    bus_start;
    send_byte(dev_w, a);
    send_byte(sub, a);
    bus_start;
    send_byte(dev_w | 8'h01, a);
    recv_byte(1'b1, d, g);
    bus_stop;
    check_eq(tag, {24'd0, d}, {24'd0, exp});
  endtask

  task automatic t_reset_state;
    check_eq("R8 SDA released after reset", {31'd0, sda_pull_o}, 32'd0);
    read_one(8'hB8, 8'h40, "R8 register reads 00 after reset", 8'h00);
  endtask

  task automatic t_write_read;
    logic a;
    logic g;
    logic [7:0] d;
    bus_start;
    send_byte(8'hB8, a); check_eq("R1 write address B8 ACKed", {31'd0, a}, 32'd1);
    send_byte(8'h10, a); check_eq("R3 subaddress ACKed", {31'd0, a}, 32'd1);
    send_byte(8'hA5, a); check_eq("R3 first data ACKed", {31'd0, a}, 32'd1);
    send_byte(8'h3C, a); check_eq("R3 second data ACKed", {31'd0, a}, 32'd1);
    bus_stop;
    bus_start;
    send_byte(8'hB8, a);
    send_byte(8'h10, a);
    bus_start;
    send_byte(8'hB9, a); check_eq("R1 read address B9 ACKed", {31'd0, a}, 32'd1);
    recv_byte(1'b0, d, g);
    check_eq("R4 read first byte MSB first", {24'd0, d}, 32'hA5);
    check_eq("R9 pull stable while SCL high", {31'd0, g}, 32'd0);
    recv_byte(1'b1, d, g);
    check_eq("R5 read advances pointer", {24'd0, d}, 32'h3C);
    check_eq("R9 pull stable on second byte", {31'd0, g}, 32'd0);
    bus_stop;
  endtask

  task automatic t_mismatch;
    logic a;
    bus_start;
    send_byte(8'hBA, a); check_eq("R7 wrong address not ACKed", {31'd0, a}, 32'd0);
    send_byte(8'h10, a); check_eq("R7 byte after mismatch not ACKed", {31'd0, a}, 32'd0);
    send_byte(8'h55, a); check_eq("R7 data after mismatch not ACKed", {31'd0, a}, 32'd0);
    bus_stop;
    read_one(8'hB8, 8'h10, "R7 register unchanged after mismatch", 8'hA5);
  endtask

  task automatic t_wrap;
    logic a;
    logic g;
    logic [7:0] d;
    bus_start;
    send_byte(8'hB8, a);
    send_byte(8'hFF, a);
    send_byte(8'h11, a);
    send_byte(8'h22, a); check_eq("R5 byte past FF ACKed", {31'd0, a}, 32'd1);
    bus_stop;
    read_one(8'hB8, 8'h00, "R5 write wrapped into register 00", 8'h22);
    bus_start;
    send_byte(8'hB8, a);
    send_byte(8'hFF, a);
    bus_start;
    send_byte(8'hB9, a);
    recv_byte(1'b0, d, g);
    check_eq("R5 read at FF", {24'd0, d}, 32'h11);
    recv_byte(1'b1, d, g);
    check_eq("R5 read wraps to 00", {24'd0, d}, 32'h22);
    bus_stop;
  endtask

  task automatic t_ptr_keep;
    logic a;
    logic g;
    logic [7:0] d;
    bus_start;
    send_byte(8'hB8, a);
    send_byte(8'h20, a);
    send_byte(8'h77, a);
    send_byte(8'h88, a);
    bus_stop;
    bus_start;
    send_byte(8'hB8, a);
    send_byte(8'h20, a);
    send_byte(8'h99, a);
    bus_start;
    send_byte(8'hB9, a);
    recv_byte(1'b1, d, g);
    check_eq("R4 pointer kept across repeated START", {24'd0, d}, 32'h88);
    bus_stop;
    read_one(8'hB8, 8'h20, "R3 overwrite stored", 8'h99);
  endtask

  task automatic t_nak;
    logic a;
    logic g;
    logic [7:0] d;
    bus_start;
    send_byte(8'hB8, a);
    send_byte(8'h10, a);
    bus_start;
    send_byte(8'hB9, a);
    recv_byte(1'b1, d, g);
    #(2*Q);
    check_eq("R6 SDA released after NAK", {31'd0, sda_pull_o}, 32'd0);
    recv_byte(1'b1, d, g);
    check_eq("R6 clocking after NAK reads ones", {24'd0, d}, 32'hFF);
    bus_stop;
  endtask

  task automatic t_after_stop;
    logic a;
    m_scl = 1'b0; #Q;
    send_byte(8'hB8, a);
    check_eq("R10 byte without START after STOP not ACKed", {31'd0, a}, 32'd0);
    bus_stop;
  endtask

  task automatic t_strap;
    logic a;
    do_reset(1'b1);
    @(negedge clk) addr_strap = 1'b0;
    #(2*Q);
    bus_start;
    send_byte(8'hBA, a); check_eq("R2 strap 1 latched, BA ACKed", {31'd0, a}, 32'd1);
    send_byte(8'h10, a);
    send_byte(8'h5A, a);
    bus_stop;
    bus_start;
    send_byte(8'hB8, a); check_eq("R2 later strap change ignored, B8 not ACKed", {31'd0, a}, 32'd0);
    bus_stop;
    read_one(8'hBA, 8'h10, "R1 read via BB with strap 1", 8'h5A);
    read_one(8'hBA, 8'h11, "R8 reset cleared register 11", 8'h00);
  endtask

  initial begin
    #(1_500_000);
    total++;
    bad++;
    $display("FAIL watchdog R1..: actual=timeout expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    do_reset(1'b0);
    t_reset_state;
    t_write_read;
    t_mismatch;
    t_wrap;
    t_ptr_keep;
    t_nak;
    t_after_stop;
    t_strap;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule